// File: doc/BRIEF.md
# Two-Tier Grouped Priority Arbiter

This block arbitrates one shared secondary bus among nine external masters and the bridge's own secondary-side request. All requests and grants are active-low. At most one grant is driven at a time, and it stays with its holder until that holder releases its request.

A 32-bit configuration word assigns every requester to one of two tiers. Inside the high tier, grants rotate round-robin. All members of the low tier share one extra position in that high-tier rotation. The low tier runs its own round-robin to decide which of its members takes that shared position. Software can move any requester between tiers at run time.

A tier change is used at the next arbitration decision. It never takes away a grant that is already held.

Top module: `grouped_arb`

## Requirements
- R1: After reset the configuration word reads 0x0200_0000 (bridge requester in the high tier, all external requesters in the low tier), and every grant output is high.
- R2: When cfg_we_i is high at a rising clock edge, the word is written. Bit 16+i is the tier of external requester i (i = 0..8), and bit 25 is the tier of the bridge requester (index 9). 1 selects the high tier and 0 selects the low tier. The read value on cfg_rdata_o reflects a write from the clock edge that follows it.
- R3: Bits 31:26 and 15:0 always read 0, and writing them has no effect on any other bit.
- R4: At most one grant output is low. A newly issued grant goes only to a requester whose request was low in the decision cycle.
- R5: While the current holder keeps its request low, its grant stays. A decision is made only in a cycle where no grant is held or the holder's request is high.
- R6: Decisions use the request levels present at a rising edge. The resulting grant appears just after that edge, and no grant changes between edges.
- R7: The high-tier rotation visits positions 0..9 (requester indices, with 9 the bridge) and then position 10 (the low-tier slot), then wraps. Each search starts at the position after the last position granted. After reset, the search starts at position 0.
- R8: The low-tier rotation visits low-tier requesters in index order 0..9. It starts after the last requester granted through the low-tier slot, starts at 0 after reset, and advances only when the low slot wins.
- R9: The low-tier slot competes whenever any low-tier request is low. If no high-tier member requests, a low-tier requester is granted.
- R10: A tier write made while a grant is held leaves that grant in place. The new tiers apply from the next decision.
- R11: In the edge after a cycle with no request low, all grant outputs are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_ni | input | 9 | External master requests, active low |
| own_req_ni | input | 1 | Bridge secondary-side request, active low |
| gnt_no | output | 9 | External master grants, active low |
| own_gnt_no | output | 1 | Bridge grant, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 32 | Configuration write data |
| cfg_rdata_o | output | 32 | Configuration read data |

## Verification
The bench builds the block with its default of nine external requesters, which gives ten requesters and an eleven-position high-tier ring. At that size all 1024 tier assignments can be written in turn. Each assignment is followed by a run of pseudo-random request patterns, some sparse and some dense, with holders that sometimes keep and sometimes drop their requests. This reaches every mix of tier membership, the wrap of both rotations, and the low slot winning by default. Directed phases cover the reset value, reserved-bit writes, the idle case, the grant timing at the clock edge, and a tier rewrite under a held grant.

// File: rtl/arb_pkg.sv
package arb_pkg;
  localparam int REG_W    = 32;
  localparam int TIER_LSB = 16;

  function automatic logic [REG_W-1:0] tier_mask(input int nreq);
    logic [REG_W-1:0] m;
    m = '0;
    for (int i = 0; i < nreq; i++) m[TIER_LSB+i] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/arb_tier_reg.sv
module arb_tier_reg
  import arb_pkg::*;
#(
  parameter int NREQ = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [NREQ-1:0]  tier_o,
  output logic [REG_W-1:0] rdata_o
);
  localparam int TOP = TIER_LSB + NREQ - 1;
  // bridge requester (top index) starts in the high tier
  localparam logic [NREQ-1:0] RST_VAL = {1'b1, {(NREQ-1){1'b0}}};

  logic [NREQ-1:0] tier_q;
  logic            unused_wbits;

  assign unused_wbits = ^{wdata_i[REG_W-1:TOP+1], wdata_i[TIER_LSB-1:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   tier_q <= RST_VAL;
    else if (we_i) tier_q <= wdata_i[TOP:TIER_LSB];
  end

  assign tier_o  = tier_q;
  assign rdata_o = REG_W'(tier_q) << TIER_LSB;
endmodule

// File: rtl/arb_rr_pick.sv
module arb_rr_pick #(
  parameter int W  = 11,
  parameter int IW = 4
) (
  input  logic [W-1:0]  req_i,
  input  logic [IW-1:0] last_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  // search last+1 .. last+W modulo W; nearest hit wins
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int k = W; k >= 1; k--) begin
      int p;
      p = int'(last_i) + k;
      if (p >= W) p = p - W;
      if (req_i[p]) begin
        found_o = 1'b1;
        idx_o   = IW'(p);
      end
    end
  end
endmodule

// File: rtl/grouped_arb.sv
module grouped_arb
  import arb_pkg::*;
#(
  parameter int N_EXT = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_EXT-1:0] req_ni,
  input  logic             own_req_ni,
  output logic [N_EXT-1:0] gnt_no,
  output logic             own_gnt_no,
  input  logic             cfg_we_i,
  input  logic [REG_W-1:0] cfg_wdata_i,
  output logic [REG_W-1:0] cfg_rdata_o
);
  localparam int NREQ     = N_EXT + 1;
  localparam int NPOS     = NREQ + 1;
  localparam int IW       = $clog2(NPOS);
  localparam int LOW_SLOT = NREQ;

  logic [NREQ-1:0] req, tier, lo_vec, gnt;
  logic [NPOS-1:0] hi_vec;
  logic            hold_q, holder_active, decide;
  logic [IW-1:0]   idx_q, hi_ptr_q, lo_ptr_q;
  logic            hi_found, lo_found;
  logic [IW-1:0]   hi_idx, lo_idx;

  assign req = {~own_req_ni, ~req_ni};

  arb_tier_reg #(.NREQ(NREQ)) u_tier (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (cfg_we_i),
    .wdata_i(cfg_wdata_i),
    .tier_o (tier),
    .rdata_o(cfg_rdata_o)
  );

  assign lo_vec = req & ~tier;
  assign hi_vec = {|lo_vec, req & tier};

  arb_rr_pick #(.W(NPOS), .IW(IW)) u_hi_pick (
    .req_i  (hi_vec),
    .last_i (hi_ptr_q),
    .found_o(hi_found),
    .idx_o  (hi_idx)
  );

  arb_rr_pick #(.W(NREQ), .IW(IW)) u_lo_pick (
    .req_i  (lo_vec),
    .last_i (lo_ptr_q),
    .found_o(lo_found),
    .idx_o  (lo_idx)
  );

  assign holder_active = hold_q && req[idx_q];
  assign decide        = !holder_active;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q   <= 1'b0;
      idx_q    <= '0;
      hi_ptr_q <= IW'(LOW_SLOT);
      lo_ptr_q <= IW'(NREQ - 1);
    end else if (decide) begin
      hold_q <= hi_found;
      if (hi_found) begin
        hi_ptr_q <= hi_idx;
        if (hi_idx == IW'(LOW_SLOT)) begin
          if (lo_found) begin
            idx_q    <= lo_idx;
            lo_ptr_q <= lo_idx;
          end
        end else begin
          idx_q <= hi_idx;
        end
      end
    end
  end

  always_comb begin
    gnt = '0;
    if (hold_q) gnt[idx_q] = 1'b1;
  end

  assign gnt_no     = ~gnt[N_EXT-1:0];
  assign own_gnt_no = ~gnt[NREQ-1];
endmodule

// File: rtl/grouped_arb_checker.sv
module grouped_arb_checker
  import arb_pkg::*;
#(
  parameter int N_EXT = 9
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_EXT-1:0] req_ni,
  input logic             own_req_ni,
  input logic [N_EXT-1:0] gnt_no,
  input logic             own_gnt_no,
  input logic             cfg_we_i,
  input logic [REG_W-1:0] cfg_wdata_i,
  input logic [REG_W-1:0] cfg_rdata_o
);
  localparam int NREQ = N_EXT + 1;
  localparam logic [REG_W-1:0] MASK = tier_mask(NREQ);

  logic [NREQ-1:0] gv, rv;
  assign gv = ~{own_gnt_no, gnt_no};
  assign rv = ~{own_req_ni, req_ni};

  a_r4_one_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gv));

  a_r4_grant_to_requester: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gv != '0 && gv != $past(gv)) |-> (($past(rv) & gv) != '0));

  a_r5_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rv & gv) != '0) |=> (gv == $past(gv)));

  a_r11_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rv == '0) |=> (gv == '0));

  a_r2_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |=> (cfg_rdata_o == ($past(cfg_wdata_i) & MASK)));

  a_r3_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cfg_rdata_o & ~MASK) == '0));
endmodule

bind grouped_arb grouped_arb_checker #(.N_EXT(N_EXT)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_ni     (req_ni),
  .own_req_ni (own_req_ni),
  .gnt_no     (gnt_no),
  .own_gnt_no (own_gnt_no),
  .cfg_we_i   (cfg_we_i),
  .cfg_wdata_i(cfg_wdata_i),
  .cfg_rdata_o(cfg_rdata_o)
);

// File: tb/grouped_arb_test.sv
module grouped_arb_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [8:0]  req_ni = '1;
  logic        own_req_ni = 1'b1;
  logic [8:0]  gnt_no;
  logic        own_gnt_no;
  logic        cfg_we_i = 1'b0;
  logic [31:0] cfg_wdata_i = '0;
  logic [31:0] cfg_rdata_o;

  int  vectors = 0;
  int  miscomp = 0;
  bit  done = 0;

  // reference state
  bit [9:0] m_tier = 10'h200;
  bit       m_hold = 0;
  int       m_idx = 0;
  int       m_hi = 10;
  int       m_lo = 9;
  bit [31:0] lfsr = 32'h1ace_b00c;

  always #5 clk_i = ~clk_i;

  grouped_arb uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_ni(req_ni), .own_req_ni(own_req_ni),
    .gnt_no(gnt_no), .own_gnt_no(own_gnt_no), .cfg_we_i(cfg_we_i),
    .cfg_wdata_i(cfg_wdata_i), .cfg_rdata_o(cfg_rdata_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscomp++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] gnt_act();
    return {22'b0, ~own_gnt_no, ~gnt_no};
  endfunction

  function automatic logic [31:0] gnt_exp();
    return m_hold ? (32'd1 << m_idx) : 32'd0;
  endfunction

  task automatic model_step(input bit [9:0] r);
    bit [10:0] hv;
    bit found;
    int w;
    if (m_hold && r[m_idx]) return;
    hv = {|(r & ~m_tier), r & m_tier};
    found = 0; w = 0;
    for (int k = 1; k <= 11; k++) begin
      int p = (m_hi + k) % 11;
      if (!found && hv[p]) begin found = 1; w = p; end
    end
    m_hold = found;
    if (!found) return;
    m_hi = w;
    if (w == 10) begin
      bit lf = 0;
      for (int k = 1; k <= 10; k++) begin
        int p = (m_lo + k) % 10;
        if (!lf && r[p] && !m_tier[p]) begin lf = 1; m_idx = p; m_lo = p; end
      end
    end else begin
      m_idx = w;
    end
  endtask

  // one clock: drive at negedge, reference update at edge, sample just after
  task automatic cyc(input string tag, input bit [9:0] r, input bit we, input logic [31:0] wd);
    @(negedge clk_i);
    req_ni = ~r[8:0]; own_req_ni = ~r[9];
    cfg_we_i = we; cfg_wdata_i = wd;
    @(posedge clk_i);
    model_step(r);
    if (we) m_tier = wd[25:16];
    #1;
    chk(tag, gnt_act(), gnt_exp());
    if (we) chk("R2", cfg_rdata_o, wd & 32'h03FF_0000);
    cfg_we_i = 1'b0;
  endtask

  function automatic bit [31:0] next_lfsr(input bit [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      miscomp++;
      $display("FAIL watchdog expired act=hung exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    #1;
    chk("R1", cfg_rdata_o, 32'h0200_0000);
    chk("R1", gnt_act(), 32'd0);
    @(negedge clk_i); rst_ni = 1'b1;

    // idle: no request, no grant
    for (int i = 0; i < 3; i++) cyc("R11", 10'h000, 0, '0);

    // reserved bits: only 25:16 stick
    cyc("R3", 10'h000, 1, 32'hFFFF_FFFF);
    chk("R3", cfg_rdata_o, 32'h03FF_0000);
    cyc("R3", 10'h000, 1, 32'hFC00_FFFF);
    chk("R3", cfg_rdata_o, 32'h0000_0000);

    // edge timing: request seen only at the edge
    @(negedge clk_i);
    req_ni = 9'h1FB; own_req_ni = 1'b1;   // requester 2 low
    #2;
    chk("R6", gnt_act(), 32'd0);
    @(posedge clk_i); model_step(10'h004); #1;
    chk("R6", gnt_act(), 32'h4);

    // all low tier, all requesting, holder drops each cycle: rotation
    for (int i = 0; i < 12; i++) begin
      bit [9:0] r = 10'h3FF;
      if (m_hold) r[m_idx] = 1'b0;
      cyc("R8", r, 0, '0);
    end
    // only low members request while high members exist: low slot wins
    cyc("R9", 10'h000, 1, 32'h0300_0000);   // 8,9 high
    for (int i = 0; i < 6; i++) cyc("R9", 10'h00F, 0, '0);

    // tier rewrite under held grant
    cyc("R10", 10'h000, 0, '0);
    cyc("R10", 10'h008, 0, '0);
    cyc("R10", 10'h00C, 1, 32'h0004_0000);  // 2 high, 3 holds
    chk("R10", gnt_act(), 32'h8);
    cyc("R10", 10'h004, 0, '0);             // 3 drops, 2 takes it
    chk("R10", gnt_act(), 32'h4);

    // sweep over all tier assignments
    for (int t = 0; t < 1024; t++) begin
      cyc("R7", 10'h000, 1, {6'b0, 10'(t), 16'h0});
      for (int j = 0; j < 12; j++) begin
        bit [9:0] r;
        lfsr = next_lfsr(lfsr); lfsr = next_lfsr(lfsr);
        r = t[0] ? (lfsr[9:0] & lfsr[19:10]) : (lfsr[9:0] | lfsr[19:10]);
        if (m_hold && lfsr[25]) r[m_idx] = 1'b1;
        cyc(j[0] ? "R5" : "R4", r, 0, '0);
      end
    end
    for (int i = 0; i < 2; i++) cyc("R11", 10'h000, 0, '0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
    $finish;
  end
endmodule